// File: doc/BRIEF.md
# Thread Interrupt Priority Presenter

This block holds the interrupt context of one hardware thread at one exception level. Incoming notifications each carry a priority from 0 to 7. Each one sets a bit in an eight-bit pending buffer. The block keeps a pending-priority register that follows the most favoured pending bit, where a numerically lower value is more favoured. It compares that register against the current-priority register that software controls. When the pending priority is strictly more favoured, the block raises its interrupt line and sets an exception flag in the notification-source register.

Software reaches the context through a register-access port. Two page-select bits give four views: physical (0b00), hypervisor (0b01), OS (0b10) and user (0b11). The port can read any register, write the current priority, or issue an acknowledge load. The acknowledge returns the flag and the pending priority. It then moves the pending priority into the current priority and retires the matching pending bit. Priority 7 is kept for hypervisor escalation, so a notification at that level only lands when the escalate qualifier is high.

Top module: `tip_presenter`

## Requirements
- R1: A notification at priority 0 to 6 sets bit p of the pending buffer (bit 0 = priority 0) on the next clock edge.
- R2: A notification at priority 7 sets bit 7 only when `ntf_esc` is high. Otherwise the pending buffer is left unchanged.
- R3: The pending-priority register equals the index of the lowest set pending bit. It reads 0xFF when the buffer is empty.
- R4: `irq` and the exception flag (bit 7 of the notification-source register, all other bits zero) are high exactly when pending priority < current priority. Both are re-evaluated one edge after any input that changes either register.
- R5: `acc_op` = 01 (set current priority) from pages 00, 01 or 10 loads `acc_wdata` into the current priority on the next edge.
- R6: A set-current-priority access from page 11 (user view) leaves the current priority unchanged.
- R7: `acc_op` = 10 (acknowledge) with the flag set returns {notification-source, pending priority} on `acc_rdata` in the same cycle, with values from before the access. On the next edge the current priority takes the old pending priority, and that pending bit and the flag are cleared.
- R8: An acknowledge with the flag clear returns the same data layout and changes no state.
- R9: When a notification and an acknowledge arrive in the same cycle, the acknowledge acts on the state before the notification. The notification bit is merged in afterwards, and presentation is re-evaluated on the merged state.
- R10: `acc_op` = 00 returns the register chosen by `acc_sel` in `acc_rdata[7:0]`, with the upper byte zero. The selector values are 0 = pending buffer, 1 = pending priority, 2 = current priority, 3 = notification-source.
- R11: Synchronous reset clears the pending buffer, the notification-source register and the current priority (0x00, all masked). It sets the pending priority to 0xFF and drives `irq` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ntf_valid | input | 1 | Notification strobe |
| ntf_prio | input | 3 | Priority of the notification |
| ntf_esc | input | 1 | Escalation qualifier that admits priority 7 |
| acc_valid | input | 1 | Register access strobe |
| acc_page | input | 2 | View page: 00 physical, 01 hypervisor, 10 OS, 11 user |
| acc_op | input | 2 | 00 read, 01 set current priority, 10 acknowledge, 11 no-op |
| acc_sel | input | 2 | Register selector for reads |
| acc_wdata | input | 8 | New current priority |
| acc_rdata | output | 16 | Read or acknowledge data, combinational |
| irq | output | 1 | Interrupt line to the thread |

## Verification
The vector walk builds several pending sets with a single bit, with several bits, and with the reserved top level. Each set is probed with current priorities of 0x00, mid-range values, the boundary where pending equals current, and 0xFF. This separates a strict compare from a non-strict one and separates an all-masked context from an open one. Acknowledges are issued both with and without the flag set, and from different pages. A notification is combined with an acknowledge at the same priority, which shows whether the retire happens before or after the merge. User-page writes and unescalated priority-7 notifications are checked by reading the current priority and the pending buffer back through the read port.

// File: rtl/tip_pkg.sv
package tip_pkg;
    localparam int NUM_PRIO  = 8;
    localparam int PRIO_W    = $clog2(NUM_PRIO);
    localparam int REG_W     = 8;
    localparam int RD_W      = 2 * REG_W;
    localparam int EO_BIT    = REG_W - 1;
    localparam logic [REG_W-1:0] PRIO_NONE = '1;
    localparam logic [PRIO_W-1:0] ESC_PRIO = PRIO_W'(NUM_PRIO - 1);

    typedef enum logic [1:0] {PG_PHYS, PG_HYP, PG_OS, PG_USER} page_e;
    typedef enum logic [1:0] {OP_READ, OP_SET_CPPR, OP_ACK, OP_NONE} op_e;
    typedef enum logic [1:0] {SEL_PEND, SEL_PIPR, SEL_CPPR, SEL_NSR} sel_e;

    typedef struct packed {
        logic [NUM_PRIO-1:0] pend;
        logic [REG_W-1:0]    pipr;
        logic [REG_W-1:0]    cppr;
        logic                eo;
    } ctx_t;

    function automatic logic [NUM_PRIO-1:0] prio_mask(input logic [PRIO_W-1:0] p);
        return NUM_PRIO'(1) << p;
    endfunction

    function automatic logic [REG_W-1:0] nsr_of(input logic eo);
        logic [REG_W-1:0] v;
        v = '0;
        v[EO_BIT] = eo;
        return v;
    endfunction
endpackage

// File: rtl/tip_prio_enc.sv
module tip_prio_enc
    import tip_pkg::*;
(
    input  logic [NUM_PRIO-1:0] pend,
    output logic [REG_W-1:0]    best
);
    always_comb begin
        best = PRIO_NONE;
        for (int i = NUM_PRIO - 1; i >= 0; i--) begin
            if (pend[i]) best = REG_W'(i);
        end
    end
endmodule

// File: rtl/tip_ctx_update.sv
module tip_ctx_update
    import tip_pkg::*;
(
    input  ctx_t              cur,
    input  logic              ntf_valid,
    input  logic [PRIO_W-1:0] ntf_prio,
    input  logic              ntf_esc,
    input  logic              acc_valid,
    input  page_e             acc_page,
    input  op_e               acc_op,
    input  logic [REG_W-1:0]  acc_wdata,
    output ctx_t              nxt
);
    logic                ntf_ok;
    logic                do_ack;
    logic                do_wr;
    logic [NUM_PRIO-1:0] pend_ack;
    logic [NUM_PRIO-1:0] pend_new;
    logic [REG_W-1:0]    cppr_new;
    logic [REG_W-1:0]    pipr_new;

    assign ntf_ok = ntf_valid && ((ntf_prio != ESC_PRIO) || ntf_esc);
    assign do_ack = acc_valid && (acc_op == OP_ACK) && cur.eo;
    assign do_wr  = acc_valid && (acc_op == OP_SET_CPPR) && (acc_page != PG_USER);

    // acknowledge retires against the pre-notify state, then the notify merges
    always_comb begin
        pend_ack = cur.pend;
        cppr_new = cur.cppr;
        if (do_ack) begin
            pend_ack[cur.pipr[PRIO_W-1:0]] = 1'b0;
            cppr_new = cur.pipr;
        end
        if (do_wr) cppr_new = acc_wdata;
        pend_new = pend_ack | (ntf_ok ? prio_mask(ntf_prio) : '0);
    end

    tip_prio_enc u_enc (
        .pend (pend_new),
        .best (pipr_new)
    );

    always_comb begin
        nxt.pend = pend_new;
        nxt.pipr = pipr_new;
        nxt.cppr = cppr_new;
        nxt.eo   = (pipr_new < cppr_new);
    end
endmodule

// File: rtl/tip_rd_mux.sv
module tip_rd_mux
    import tip_pkg::*;
(
    input  ctx_t            cur,
    input  logic            acc_valid,
    input  op_e             acc_op,
    input  sel_e            acc_sel,
    output logic [RD_W-1:0] rdata
);
    logic [REG_W-1:0] reg_val;

    always_comb begin
        unique case (acc_sel)
            SEL_PEND: reg_val = REG_W'(cur.pend);
            SEL_PIPR: reg_val = cur.pipr;
            SEL_CPPR: reg_val = cur.cppr;
            SEL_NSR:  reg_val = nsr_of(cur.eo);
            default:  reg_val = '0;
        endcase
    end

    always_comb begin
        rdata = '0;
        if (acc_valid) begin
            if (acc_op == OP_READ)     rdata = {{REG_W{1'b0}}, reg_val};
            else if (acc_op == OP_ACK) rdata = {nsr_of(cur.eo), cur.pipr};
        end
    end
endmodule

// File: rtl/tip_presenter.sv
module tip_presenter
    import tip_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ntf_valid,
    input  logic [PRIO_W-1:0] ntf_prio,
    input  logic              ntf_esc,
    input  logic              acc_valid,
    input  logic [1:0]        acc_page,
    input  logic [1:0]        acc_op,
    input  logic [1:0]        acc_sel,
    input  logic [REG_W-1:0]  acc_wdata,
    output logic [RD_W-1:0]   acc_rdata,
    output logic              irq
);
    ctx_t ctx_q;
    ctx_t ctx_d;

    tip_ctx_update u_upd (
        .cur       (ctx_q),
        .ntf_valid (ntf_valid),
        .ntf_prio  (ntf_prio),
        .ntf_esc   (ntf_esc),
        .acc_valid (acc_valid),
        .acc_page  (page_e'(acc_page)),
        .acc_op    (op_e'(acc_op)),
        .acc_wdata (acc_wdata),
        .nxt       (ctx_d)
    );

    tip_rd_mux u_rd (
        .cur       (ctx_q),
        .acc_valid (acc_valid),
        .acc_op    (op_e'(acc_op)),
        .acc_sel   (sel_e'(acc_sel)),
        .rdata     (acc_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q.pend <= '0;
            ctx_q.pipr <= PRIO_NONE;
            ctx_q.cppr <= '0;
            ctx_q.eo   <= 1'b0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign irq = ctx_q.eo;
endmodule

// File: rtl/tip_presenter_chk.sv
module tip_presenter_chk
    import tip_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                ntf_valid,
    input logic [PRIO_W-1:0]   ntf_prio,
    input logic                acc_valid,
    input logic [1:0]          acc_page,
    input logic [1:0]          acc_op,
    input logic                irq,
    input logic [NUM_PRIO-1:0] pend,
    input logic [REG_W-1:0]    pipr,
    input logic [REG_W-1:0]    cppr
);
    // R3
    empty_pipr_chk: assert property (@(posedge clk) disable iff (rst)
        (pend == '0) |-> (pipr == PRIO_NONE));

    // R4
    irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (pipr < cppr) |-> irq);

    // R4
    irq_justified_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (pipr < cppr));

    // R1
    notify_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (ntf_valid && (ntf_prio != ESC_PRIO)) |=> pend[$past(ntf_prio)]);

    // R6
    user_write_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_op == 2'b01 && acc_page == 2'b11) |=> $stable(cppr));

    // R7
    ack_moves_pipr_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_op == 2'b10 && irq) |=> (cppr == $past(pipr)));

    // R8
    ack_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_op == 2'b10 && !irq) |=> $stable(cppr));
endmodule

bind tip_presenter tip_presenter_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ntf_valid (ntf_valid),
    .ntf_prio  (ntf_prio),
    .acc_valid (acc_valid),
    .acc_page  (acc_page),
    .acc_op    (acc_op),
    .irq       (irq),
    .pend      (ctx_q.pend),
    .pipr      (ctx_q.pipr),
    .cppr      (ctx_q.cppr)
);

// File: tb/tip_presenter_tb.sv
module tip_presenter_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        nv;
        logic [2:0]  np;
        logic        esc;
        logic [1:0]  op;
        logic [1:0]  page;
        logic [7:0]  wd;
        logic [15:0] er;
        logic        ei;
        logic [7:0]  epend;
        logic [7:0]  epipr;
        logic [7:0]  ecppr;
        logic [3:0]  rq;
    } vec_t;

    localparam int NVEC = 18;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1,3'd3,1'b0,2'd3,2'd0,8'h00,16'h0000,1'b0,8'h08,8'h03,8'h00,4'd1},  // R1
        '{1'b0,3'd0,1'b0,2'd1,2'd2,8'hFF,16'h0000,1'b1,8'h08,8'h03,8'hFF,4'd5},  // R5
        '{1'b1,3'd7,1'b0,2'd3,2'd0,8'h00,16'h0000,1'b1,8'h08,8'h03,8'hFF,4'd2},  // R2
        '{1'b1,3'd7,1'b1,2'd3,2'd0,8'h00,16'h0000,1'b1,8'h88,8'h03,8'hFF,4'd2},  // R2
        '{1'b1,3'd1,1'b0,2'd3,2'd0,8'h00,16'h0000,1'b1,8'h8A,8'h01,8'hFF,4'd3},  // R3
        '{1'b0,3'd0,1'b0,2'd2,2'd2,8'h00,16'h8001,1'b0,8'h88,8'h03,8'h01,4'd7},  // R7
        '{1'b0,3'd0,1'b0,2'd2,2'd2,8'h00,16'h0003,1'b0,8'h88,8'h03,8'h01,4'd8},  // R8
        '{1'b0,3'd0,1'b0,2'd1,2'd3,8'h05,16'h0000,1'b0,8'h88,8'h03,8'h01,4'd6},  // R6
        '{1'b0,3'd0,1'b0,2'd1,2'd1,8'h05,16'h0000,1'b1,8'h88,8'h03,8'h05,4'd5},  // R5
        '{1'b1,3'd3,1'b0,2'd2,2'd2,8'h00,16'h8003,1'b0,8'h88,8'h03,8'h03,4'd9},  // R9
        '{1'b1,3'd0,1'b0,2'd3,2'd0,8'h00,16'h0000,1'b1,8'h89,8'h00,8'h03,4'd4},  // R4
        '{1'b0,3'd0,1'b0,2'd1,2'd0,8'h00,16'h0000,1'b0,8'h89,8'h00,8'h00,4'd4},  // R4
        '{1'b0,3'd0,1'b0,2'd1,2'd0,8'hFF,16'h0000,1'b1,8'h89,8'h00,8'hFF,4'd5},  // R5
        '{1'b0,3'd0,1'b0,2'd2,2'd0,8'h00,16'h8000,1'b0,8'h88,8'h03,8'h00,4'd7},  // R7
        '{1'b0,3'd0,1'b0,2'd1,2'd2,8'hFF,16'h0000,1'b1,8'h88,8'h03,8'hFF,4'd4},  // R4
        '{1'b0,3'd0,1'b0,2'd2,2'd1,8'h00,16'h8003,1'b0,8'h80,8'h07,8'h03,4'd7},  // R7
        '{1'b0,3'd0,1'b0,2'd1,2'd2,8'h08,16'h0000,1'b1,8'h80,8'h07,8'h08,4'd4},  // R4
        '{1'b0,3'd0,1'b0,2'd2,2'd2,8'h00,16'h8007,1'b0,8'h00,8'hFF,8'h07,4'd3}   // R3
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ntf_valid = 1'b0;
    logic [2:0]  ntf_prio = '0;
    logic        ntf_esc = 1'b0;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_page = '0;
    logic [1:0]  acc_op = 2'd3;
    logic [1:0]  acc_sel = '0;
    logic [7:0]  acc_wdata = '0;
    logic [15:0] acc_rdata;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tip_presenter u_dut (
        .clk       (clk),
        .rst       (rst),
        .ntf_valid (ntf_valid),
        .ntf_prio  (ntf_prio),
        .ntf_esc   (ntf_esc),
        .acc_valid (acc_valid),
        .acc_page  (acc_page),
        .acc_op    (acc_op),
        .acc_sel   (acc_sel),
        .acc_wdata (acc_wdata),
        .acc_rdata (acc_rdata),
        .irq       (irq)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic peek(input logic [1:0] sel, output logic [15:0] val);
        acc_valid = 1'b1;
        acc_op    = 2'd0;
        acc_sel   = sel;
        #1;
        val = acc_rdata;
    endtask

    task automatic idle();
        ntf_valid = 1'b0;
        ntf_esc   = 1'b0;
        acc_valid = 1'b0;
        acc_op    = 2'd3;
    endtask

    task automatic check_state(input string tag, input logic ei, input logic [7:0] ep,
                               input logic [7:0] epi, input logic [7:0] ec);
        logic [15:0] v;
        check({tag, " irq"}, {15'd0, irq}, {15'd0, ei});
        peek(2'd0, v); check({tag, " pend R10"}, v, {8'h00, ep});
        peek(2'd1, v); check({tag, " pipr R3"},  v, {8'h00, epi});
        peek(2'd2, v); check({tag, " cppr"},     v, {8'h00, ec});
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v;
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R11: reset state
        check_state("R11 reset", 1'b0, 8'h00, 8'hFF, 8'h00);
        peek(2'd3, v); check("R11 nsr", v, 16'h0000);

        for (int i = 0; i < NVEC; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VEC[i].rq, i);
            @(negedge clk);
            ntf_valid = VEC[i].nv;
            ntf_prio  = VEC[i].np;
            ntf_esc   = VEC[i].esc;
            acc_valid = (VEC[i].op != 2'd3);
            acc_op    = VEC[i].op;
            acc_page  = VEC[i].page;
            acc_wdata = VEC[i].wd;
            #1;
            if (VEC[i].op == 2'd2) check({tag, " ack data"}, acc_rdata, VEC[i].er);
            @(posedge clk);
            #1;
            idle();
            check_state(tag, VEC[i].ei, VEC[i].epend, VEC[i].epipr, VEC[i].ecppr);
        end

        // R4 / R10: notify at 2 with current priority 7 presents, NSR shows flag
        @(negedge clk);
        idle();
        ntf_valid = 1'b1;
        ntf_prio  = 3'd2;
        @(posedge clk);
        #1;
        idle();
        check_state("R4 directed", 1'b1, 8'h04, 8'h02, 8'h07);
        peek(2'd3, v); check("R10 nsr flag", v, 16'h0080);

        // R11: reset mid-run clears the context
        @(negedge clk);
        idle();
        rst = 1'b1;
        @(posedge clk);
        #1;
        rst = 1'b0;
        check_state("R11 rerst", 1'b0, 8'h00, 8'hFF, 8'h00);
        peek(2'd3, v); check("R11 rerst nsr", v, 16'h0000);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule